// File: doc/BRIEF.md
# Fault Blink-Code LED Sequencer

This block drives one front-panel indicator LED. When the platform reports a recoverable fault, the LED plays a timed blink code instead of the plain "power on" level. The firmware-update, video-fault, memory-fault and thermal-warning conditions each have their own code. Every duration in every code is a whole number of quarter-second steps. A prescaler derives that step from the `CLK_HZ` parameter, with one step equal to `CLK_HZ/4` clock cycles.

Video and memory faults are sticky. They keep playing until reset, even after their request line drops. The firmware-update code plays only while its request is held. A thermal warning plays a single burst of fixed length. When several codes are pending, a fixed priority picks one of them. A code that is selected or resumed always restarts from its first step, and the prescaler restarts at the same edge, so a code never opens with a partial step. When no code is playing, the LED follows the power-on input.

Top module: `led_fault_blinker`

## Requirements
- R1: While `rst_ni` is low, `led_o` and `busy_o` are 0.
- R2: While no code plays, `busy_o` is 0 and `led_o` equals the value `pwr_on_i` had at the previous rising clock edge.
- R3: A code starts at step 0 in the clock after the edge that selects it. Each step lasts exactly `CLK_HZ/4` cycles, counted from that edge.
- R4: The update code has a period of 4 steps: dark for steps 0-1 and lit for steps 2-3. It repeats while `upd_req_i` is high and stops when it drops.
- R5: The video code has a period of 26 steps: two pulses of 4 lit steps and 4 dark steps each, then 10 dark steps.
- R6: The memory code has a period of 34 steps: three pulses of 4 lit steps and 4 dark steps each, then 10 dark steps.
- R7: A single-cycle pulse on `vid_req_i` or `mem_req_i` makes its code repeat until reset.
- R8: A rising edge of `thm_req_i` starts a 32-step burst that is lit on even steps, which gives 16 blinks, and then ends. A rising edge during a burst, or holding the input high, starts no new burst.
- R9: Priority runs from thermal to update to memory to video. When a code is pre-empted and later resumes, it restarts from step 0.
- R10: `busy_o` is 1 exactly while a code is playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_req_i | input | 1 | Firmware update in progress (level) |
| vid_req_i | input | 1 | Video fault request (latched) |
| mem_req_i | input | 1 | Memory fault request (latched) |
| thm_req_i | input | 1 | Thermal warning; a rising edge starts a burst |
| pwr_on_i | input | 1 | LED level to show when no code plays |
| led_o | output | 1 | Registered LED drive |
| busy_o | output | 1 | A code is playing |

## Verification
Each code is first played alone from a clean reset. This separates the 26-step and 34-step group lengths and the dark-first update phase. Directed overlaps follow. Update is raised during a lit memory pulse and later dropped, which exposes both a wrong priority order and resuming mid-pattern instead of restarting. A thermal retrigger inside the burst and a held-high input show whether edge detection and the 32-step end are right. A seeded random mix of requests, power-level changes and resets is then compared cycle by cycle against a step-counting model in the bench.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE = 3'd0,
    MODE_VID  = 3'd1,
    MODE_MEM  = 3'd2,
    MODE_UPD  = 3'd3,
    MODE_THM  = 3'd4
  } mode_e;
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= LAST);
  // R3
  cnt_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) restart_i |=> cnt_q == '0);
endmodule

// File: rtl/led_req_arb.sv
module led_req_arb
  import led_blink_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_req_i,
  input  logic  vid_req_i,
  input  logic  mem_req_i,
  input  logic  thm_req_i,
  input  logic  thm_done_i,
  output mode_e sel_o
);
  logic vid_lat_q, mem_lat_q, thm_prev_q, thm_act_q;
  logic thm_rise, thm_eff, vid_seen, mem_seen;

  assign thm_rise = thm_req_i & ~thm_prev_q;
  // a rise while a burst runs is dropped
  assign thm_eff  = (thm_act_q & ~thm_done_i) | (thm_rise & ~thm_act_q);
  assign vid_seen = vid_lat_q | vid_req_i;
  assign mem_seen = mem_lat_q | mem_req_i;

  always_comb begin
    if (thm_eff)        sel_o = MODE_THM;
    else if (upd_req_i) sel_o = MODE_UPD;
    else if (mem_seen)  sel_o = MODE_MEM;
    else if (vid_seen)  sel_o = MODE_VID;
    else                sel_o = MODE_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_lat_q  <= 1'b0;
      mem_lat_q  <= 1'b0;
      thm_prev_q <= 1'b0;
      thm_act_q  <= 1'b0;
    end else begin
      vid_lat_q  <= vid_seen;
      mem_lat_q  <= mem_seen;
      thm_prev_q <= thm_req_i;
      thm_act_q  <= thm_eff;
    end
  end

  // R7
  mem_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_lat_q |=> mem_lat_q);
  // R7
  vid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) vid_lat_q |=> vid_lat_q);
  // R8
  thm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thm_act_q && !thm_done_i) |=> thm_act_q);
endmodule

// File: rtl/led_pattern_seq.sv
module led_pattern_seq
  import led_blink_pkg::*;
#(
  parameter int unsigned HALF_T = 2,
  parameter int unsigned ONE_T  = 4,
  parameter int unsigned GAP_T  = 10,
  parameter int unsigned VID_N  = 2,
  parameter int unsigned MEM_N  = 3,
  parameter int unsigned THM_N  = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e sel_i,
  input  logic  tick_i,
  input  logic  pwr_on_i,
  output logic  restart_o,
  output logic  thm_done_o,
  output logic  led_o,
  output logic  busy_o
);
  localparam int unsigned LEN_UPD = 2 * HALF_T;
  localparam int unsigned LEN_VID = 2 * ONE_T * VID_N + GAP_T;
  localparam int unsigned LEN_MEM = 2 * ONE_T * MEM_N + GAP_T;
  localparam int unsigned LEN_THM = 2 * THM_N;
  localparam int unsigned LEN_A   = (LEN_VID > LEN_MEM) ? LEN_VID : LEN_MEM;
  localparam int unsigned LEN_MAX = (LEN_A > LEN_THM) ? LEN_A : LEN_THM;
  localparam int unsigned SW      = $clog2(LEN_MAX + 1);

  mode_e         mode_q;
  logic [SW-1:0] step_q, step_d;

  function automatic logic [SW-1:0] last_step(mode_e m);
    case (m)
      MODE_UPD: return SW'(LEN_UPD - 1);
      MODE_VID: return SW'(LEN_VID - 1);
      MODE_MEM: return SW'(LEN_MEM - 1);
      MODE_THM: return SW'(LEN_THM - 1);
      default:  return '0;
    endcase
  endfunction

  function automatic logic lit(mode_e m, logic [SW-1:0] s);
    int unsigned p;
    p = 32'(s);
    case (m)
      MODE_UPD: return (p % (2 * HALF_T)) >= HALF_T;
      MODE_VID: return (p < 2 * ONE_T * VID_N) && ((p % (2 * ONE_T)) < ONE_T);
      MODE_MEM: return (p < 2 * ONE_T * MEM_N) && ((p % (2 * ONE_T)) < ONE_T);
      MODE_THM: return (p % 2) == 0;
      default:  return 1'b0;
    endcase
  endfunction

  assign restart_o  = (sel_i != mode_q);
  assign thm_done_o = (mode_q == MODE_THM) && tick_i && (step_q == last_step(MODE_THM));

  always_comb begin
    if (restart_o)                               step_d = '0;
    else if (tick_i && step_q == last_step(mode_q)) step_d = '0;
    else if (tick_i)                             step_d = step_q + 1'b1;
    else                                         step_d = step_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      step_q <= '0;
      led_o  <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      mode_q <= sel_i;
      step_q <= step_d;
      led_o  <= (sel_i == MODE_IDLE) ? pwr_on_i : lit(sel_i, step_d);
      busy_o <= (sel_i != MODE_IDLE);
    end
  end

  // R3
  step_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) restart_o |=> step_q == '0);
  // R3
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) step_q <= last_step(mode_q));
  // R8
  thm_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) thm_done_o |=> mode_q != MODE_THM);
  // R10
  busy_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(mode_q) == MODE_IDLE);
endmodule

// File: rtl/led_fault_blinker.sv
module led_fault_blinker
  import led_blink_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned HALF_T = 2,
  parameter int unsigned ONE_T  = 4,
  parameter int unsigned GAP_T  = 10,
  parameter int unsigned VID_N  = 2,
  parameter int unsigned MEM_N  = 3,
  parameter int unsigned THM_N  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_req_i,
  input  logic vid_req_i,
  input  logic mem_req_i,
  input  logic thm_req_i,
  input  logic pwr_on_i,
  output logic led_o,
  output logic busy_o
);
  localparam int unsigned QTR_DIV = (CLK_HZ / 4 < 1) ? 1 : CLK_HZ / 4;

  mode_e sel;
  logic  tick, restart, thm_done;

  led_tick_gen #(.DIV(QTR_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_o    (tick)
  );

  led_req_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_req_i  (upd_req_i),
    .vid_req_i  (vid_req_i),
    .mem_req_i  (mem_req_i),
    .thm_req_i  (thm_req_i),
    .thm_done_i (thm_done),
    .sel_o      (sel)
  );

  led_pattern_seq #(
    .HALF_T (HALF_T),
    .ONE_T  (ONE_T),
    .GAP_T  (GAP_T),
    .VID_N  (VID_N),
    .MEM_N  (MEM_N),
    .THM_N  (THM_N)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .tick_i     (tick),
    .pwr_on_i   (pwr_on_i),
    .restart_o  (restart),
    .thm_done_o (thm_done),
    .led_o      (led_o),
    .busy_o     (busy_o)
  );

  // R2
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !busy_o) |-> led_o == $past(pwr_on_i));
  // R9
  upd_over_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_req_i && !thm_req_i && $past(rst_ni) && $past(upd_req_i) && $past(busy_o)) |-> busy_o);
endmodule

// File: tb/led_fault_blinker_tb_top.sv
`timescale 1ns/1ps
module led_fault_blinker_tb_top;
  localparam int CLK_HZ = 16;
  localparam int DIV    = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic upd = 1'b0, vid = 1'b0, mem = 1'b0, thm = 1'b0, pwr = 1'b0;
  logic led, busy;

  always #2.5 clk = ~clk;

  led_fault_blinker #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .upd_req_i(upd), .vid_req_i(vid),
    .mem_req_i(mem), .thm_req_i(thm), .pwr_on_i(pwr), .led_o(led), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model: 0 idle, 1 video, 2 memory, 3 update, 4 thermal
  int m_mode = 0, m_t = 0;
  bit m_mem, m_vid, m_ta, m_prev, e_led, e_busy;

  function automatic bit exp_lit(int md, int t);
    int s, p;
    s = t / DIV;
    case (md)
      1: begin p = s % 26; return (p < 16) && ((p % 8) < 4); end
      2: begin p = s % 34; return (p < 24) && ((p % 8) < 4); end
      3: return (s % 4) >= 2;
      4: return (s % 2) == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag(int md);
    case (md)
      1: return "R5";
      2: return "R6";
      3: return "R4";
      4: return "R8";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_t = 0; m_mem = 0; m_vid = 0; m_ta = 0; m_prev = 0;
      e_led = 0; e_busy = 0;
    end else begin
      int nm;
      bit rise;
      rise = thm && !m_prev;
      m_prev = thm;
      m_mem = m_mem | mem;
      m_vid = m_vid | vid;
      if (m_ta && m_mode == 4 && (m_t + 1) == 32 * DIV) m_ta = 0;
      else if (!m_ta && rise) m_ta = 1;
      nm = m_ta ? 4 : upd ? 3 : m_mem ? 2 : m_vid ? 1 : 0;
      if (nm != m_mode) begin m_mode = nm; m_t = 0; end
      else m_t = m_t + 1;
      e_led  = (m_mode == 0) ? pwr : exp_lit(m_mode, m_t);
      e_busy = (m_mode != 0);
    end
  end

  task automatic chk(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(tag(m_mode), led, e_led);
      chk("R10", busy, e_busy);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; upd = 0; vid = 0; mem = 0; thm = 0;
    cyc(3);
    chk("R1", led, 1'b0);
    chk("R1", busy, 1'b0);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(1);
    do_reset();
    // R2 idle follows power level
    pwr = 1; cyc(1); chk("R2", led, 1'b1);
    pwr = 0; cyc(1); chk("R2", led, 1'b0);

    // R3 memory start alignment, R7 sticky
    mem = 1; cyc(1); mem = 0;
    cyc(4 * DIV - 1); chk("R3", led, 1'b1);
    cyc(1);           chk("R3", led, 1'b0);
    cyc(300);         chk("R7", busy, 1'b1);

    // R9 update pre-empts a lit memory pulse, memory restarts afterwards
    do_reset();
    mem = 1; cyc(1); mem = 0; cyc(2);
    chk("R6", led, 1'b1);
    upd = 1; cyc(1); chk("R9", led, 1'b0);
    cyc(2 * DIV); chk("R4", led, 1'b1);
    cyc(20);
    upd = 0; cyc(1); chk("R9", led, 1'b1);
    cyc(40);

    // R5 video alone, then memory takes over (R9)
    do_reset();
    vid = 1; cyc(1); vid = 0;
    cyc(2 * 26 * DIV); chk("R7", busy, 1'b1);
    mem = 1; cyc(1); mem = 0; chk("R9", led, 1'b1);
    cyc(34 * DIV);

    // R8 thermal burst with retrigger inside the burst
    do_reset();
    pwr = 1; thm = 1; cyc(1); chk("R8", led, 1'b1);
    cyc(DIV); chk("R8", led, 1'b0);
    thm = 0; cyc(1); thm = 1;
    cyc(32 * DIV - 1 - (DIV + 1)); chk("R8", busy, 1'b1);
    cyc(1); chk("R8", busy, 1'b0); chk("R8", led, 1'b1);
    cyc(50); chk("R8", busy, 1'b0);

    // random mix
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 300 == 0) upd = ~upd;
      if ($urandom % 250 == 0) thm = ~thm;
      vid = ($urandom % 900 == 0);
      mem = ($urandom % 1500 == 0);
      if ($urandom % 40 == 0) pwr = ~pwr;
      if ($urandom % 1800 == 0) do_reset();
      else cyc(1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule